// File: doc/BRIEF.md
# Adaptive Double-Correct Triple-Detect BCH Decoder

This block decodes one word of a shortened binary BCH code that fixes any two flipped bits and reports any three. It sits on the read path of a memory and is purely combinational. The received word holds a 14-bit check field, the data field and one overall even-parity bit. The decoder computes three syndromes: the overall parity, the first-power syndrome and the cube syndrome. From these it works out how many bits are wrong before it tries any repair.

The 2-bit count drives a three-way selection of the error vector. When no bits or three bits are wrong, an all-zero vector is used, so no repair logic is exercised. A single error goes to a per-column match against the first-power syndrome. A double error goes to a parallel search for the roots of a quadratic locator over GF(2^7). The syndromes are gated, so only the repair circuit that the count selects sees a non-zero input. The chosen vector is XORed onto the data field. A triple error raises an uncorrectable indication and leaves the data as it was received.

Top module: `bch2_adaptive_dec`

## Requirements
- R1: A valid codeword gives err_flag 00, uncorrectable 0, and data_out equal to the received data field.
- R2: err_flag bit 0 equals the parity of the number of flipped bits, taken over all 79 positions.
- R3: err_flag encodes the flipped-bit count: 00 for none, 01 for one, 10 for two, 11 for three. This holds wherever the flips fall, including the overall parity bit.
- R4: Any single flip is corrected. A flip in the check field or on the overall parity bit gives flag 01 and leaves data_out equal to the original data.
- R5: Any two flips are corrected, including pairs in which one flip is on the overall parity bit or in the check field.
- R6: For no error and for three errors the applied error vector is zero. At most one of the two repair circuits receives a non-zero syndrome.
- R7: Three flips give err_flag 11 and uncorrectable 1, and data_out equals the received data field unchanged.
- R8: Word layout. Bits 0..13 are checks, bits 14..77 carry data bits 0..63, and bit 78 makes the whole 79-bit word even parity. Position i has check columns alpha^i and alpha^(3i), with alpha a root of x^7 + x^3 + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_in | input | 79 | Received word: check field, data field and overall parity bit |
| data_out | output | 64 | Data field after the selected error vector is applied |
| err_flag | output | 2 | Classified count of flipped bits |
| uncorrectable | output | 1 | High when three flips are detected |

## Verification
The built-in checks watch three things whenever the inputs settle. A zero count always comes with both syndromes zero. The single-error match picks at most one position and the locator search marks at most two. The two repair paths are never active together, and an uncorrectable word passes through unchanged. Whether the count is right, and whether the right bits are repaired for flips in the check field, the data field and the parity bit, only the bench's encoded words with injected flips can show.

// File: rtl/bch2_pkg.sv
package bch2_pkg;
  localparam int GF_M = 7;
  localparam int GF_ORDER = (1 << GF_M) - 1;
  // reduction taps of x^7 + x^3 + 1
  localparam logic [GF_M-1:0] GF_TAPS = 7'h09;

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ONE   = 2'b01,
    ERR_TWO   = 2'b10,
    ERR_THREE = 2'b11
  } err_cnt_e;

  function automatic gf_t gf_xtime(gf_t a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_TAPS : '0);
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc = '0;
    gf_t sh = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc ^= sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic gf_t gf_cube(gf_t a);
    return gf_mul(gf_mul(a, a), a);
  endfunction

  function automatic gf_t gf_pow_alpha(int e);
    gf_t r = 'd1;
    int n = e % GF_ORDER;
    for (int k = 0; k < n; k++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/bch2_syndrome.sv
module bch2_syndrome
  import bch2_pkg::*;
#(
  parameter int N_POS = 78
) (
  input  logic [N_POS:0] cw,
  output logic           s0,
  output gf_t            s1,
  output gf_t            s3
);
  gf_t c1 [N_POS];
  gf_t c3 [N_POS];

  for (genvar i = 0; i < N_POS; i++) begin : g_col
    localparam gf_t H1 = gf_pow_alpha(i);
    localparam gf_t H3 = gf_pow_alpha(3 * i);
    assign c1[i] = cw[i] ? H1 : '0;
    assign c3[i] = cw[i] ? H3 : '0;
  end

  always_comb begin
    s1 = '0;
    s3 = '0;
    for (int i = 0; i < N_POS; i++) begin
      s1 ^= c1[i];
      s3 ^= c3[i];
    end
  end

  assign s0 = ^cw;
endmodule

// File: rtl/bch2_errcount.sv
module bch2_errcount
  import bch2_pkg::*;
(
  input  logic     s0,
  input  gf_t      s1,
  input  gf_t      s3,
  output gf_t      sigma,
  output err_cnt_e flag
);
  logic mbe;
  logic even_hit;

  assign sigma    = gf_cube(s1) ^ s3;
  assign mbe      = |sigma;
  // even count with a non-zero first syndrome: one flip sits on the parity bit
  assign even_hit = ~s0 & (|s1);
  assign flag     = err_cnt_e'({mbe | even_hit, s0});

  always_comb begin
    AST_CLEAN_SYNDROME: assert (flag != ERR_NONE || (s1 == '0 && s3 == '0))
      else $error("zero count with live syndrome"); // R3
  end
endmodule

// File: rtl/bch2_single_fix.sv
module bch2_single_fix
  import bch2_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE   = 14
) (
  input  gf_t               s1,
  output logic [DATA_W-1:0] hit
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    localparam gf_t H1 = gf_pow_alpha(i + BASE);
    assign hit[i] = (s1 == H1);
  end

  always_comb begin
    AST_SE_ONEHOT: assert ($onehot0(hit))
      else $error("single corrector marked several bits"); // R4
  end
endmodule

// File: rtl/bch2_double_fix.sv
module bch2_double_fix
  import bch2_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE   = 14
) (
  input  gf_t               s1,
  input  gf_t               sigma,
  output logic [DATA_W-1:0] hit
);
  gf_t  s1_sq;
  logic live;

  assign s1_sq = gf_mul(s1, s1);
  assign live  = |s1;

  // root test of s1*x^2 + s1^2*x + sigma at x = alpha^pos
  for (genvar i = 0; i < DATA_W; i++) begin : g_root
    localparam gf_t X  = gf_pow_alpha(i + BASE);
    localparam gf_t X2 = gf_pow_alpha(2 * (i + BASE));
    gf_t term;
    assign term   = gf_mul(s1, X2) ^ gf_mul(s1_sq, X) ^ sigma;
    assign hit[i] = live && (term == '0);
  end

  always_comb begin
    AST_DE_TWO_ROOTS: assert ($countones(hit) <= 2)
      else $error("locator has more than two roots"); // R5
  end
endmodule

// File: rtl/bch2_adaptive_dec.sv
module bch2_adaptive_dec
  import bch2_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int PAR_W = 2 * GF_M,
  localparam int N_POS = DATA_W + PAR_W,
  localparam int CW_W  = N_POS + 1
) (
  input  logic [CW_W-1:0]   code_in,
  output logic [DATA_W-1:0] data_out,
  output logic [1:0]        err_flag,
  output logic              uncorrectable
);
  logic              s0;
  gf_t               s1, s3, sigma;
  err_cnt_e          flag;
  gf_t               se_s1, de_s1, de_sigma;
  logic [DATA_W-1:0] se_hit, de_hit, err_vec, rx_data;

  bch2_syndrome #(.N_POS(N_POS)) u_syn (
    .cw(code_in), .s0(s0), .s1(s1), .s3(s3)
  );

  bch2_errcount u_cnt (
    .s0(s0), .s1(s1), .s3(s3), .sigma(sigma), .flag(flag)
  );

  // only the corrector chosen by the count sees a live syndrome
  assign se_s1    = (flag == ERR_ONE) ? s1 : '0;
  assign de_s1    = (flag == ERR_TWO) ? s1 : '0;
  assign de_sigma = (flag == ERR_TWO) ? sigma : '0;

  bch2_single_fix #(.DATA_W(DATA_W), .BASE(PAR_W)) u_se (
    .s1(se_s1), .hit(se_hit)
  );

  bch2_double_fix #(.DATA_W(DATA_W), .BASE(PAR_W)) u_de (
    .s1(de_s1), .sigma(de_sigma), .hit(de_hit)
  );

  always_comb begin
    unique case (flag)
      ERR_ONE: err_vec = se_hit;
      ERR_TWO: err_vec = de_hit;
      default: err_vec = '0;
    endcase
  end

  assign rx_data       = code_in[N_POS-1:PAR_W];
  assign data_out      = rx_data ^ err_vec;
  assign err_flag      = flag;
  assign uncorrectable = (flag == ERR_THREE);

  always_comb begin
    AST_ONE_PATH: assert (!((|se_hit) && (|de_hit)))
      else $error("both correctors active"); // R6
    AST_IDLE_PATHS: assert (!(flag == ERR_NONE || flag == ERR_THREE) ||
                            (se_hit == '0 && de_hit == '0))
      else $error("corrector active without need"); // R6
    AST_UNCORR_PASS: assert (!uncorrectable || data_out == rx_data)
      else $error("uncorrectable word altered"); // R7
  end
endmodule

// File: tb/tb_bch2_adaptive_dec.sv
module tb_bch2_adaptive_dec;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int PAR_W  = 14;
  localparam int N_POS  = DATA_W + PAR_W;
  localparam int CW_W   = N_POS + 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [CW_W-1:0]   code_in = '0;
  logic [DATA_W-1:0] data_out;
  logic [1:0]        err_flag;
  logic              uncorrectable;

  bch2_adaptive_dec dut (
    .code_in(code_in), .data_out(data_out),
    .err_flag(err_flag), .uncorrectable(uncorrectable)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0]  alog [0:126];
  logic [13:0] inv_tab [0:16383];

  function automatic logic [13:0] col(int pos);
    return {alog[(3 * pos) % 127], alog[pos % 127]};
  endfunction

  task automatic build_tables();
    logic [6:0] v = 7'd1;
    for (int k = 0; k < 127; k++) begin
      alog[k] = v;
      v = v[6] ? ({v[5:0], 1'b0} ^ 7'b0001001) : {v[5:0], 1'b0};
    end
    for (int p = 0; p < 16384; p++) begin
      logic [13:0] s = '0;
      for (int b = 0; b < 14; b++) if (p[b]) s ^= col(b);
      inv_tab[s] = 14'(p);
    end
  endtask

  function automatic logic [CW_W-1:0] encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w = '0;
    logic [13:0] s = '0;
    w[N_POS-1:PAR_W] = d;
    for (int k = 0; k < DATA_W; k++) if (d[k]) s ^= col(k + PAR_W);
    w[PAR_W-1:0] = inv_tab[s];
    w[N_POS] = ^w[N_POS-1:0];
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(logic [DATA_W-1:0] d, int n, int p0, int p1, int p2,
                          string dtag);
    logic [CW_W-1:0] w = encode(d);
    if (n > 0) w[p0] = ~w[p0];
    if (n > 1) w[p1] = ~w[p1];
    if (n > 2) w[p2] = ~w[p2];
    @(posedge clk);
    code_in = w;
    @(negedge clk);
    check("R3 flag", 64'(err_flag), 64'(n));
    check("R2 parity", 64'(err_flag[0]), 64'(n % 2));
    check(dtag, data_out, (n == 3) ? w[N_POS-1:PAR_W] : d);
    check("R7 uncorrectable", 64'(uncorrectable), 64'(n == 3));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    build_tables();
    @(negedge clk);
    // all-zero word at start is a valid codeword
    check("R1 idle flag", 64'(err_flag), 64'd0);
    check("R1 idle data", data_out, 64'd0);
    check("R1 idle unc", 64'(uncorrectable), 64'd0);

    run_case('1, 0, 0, 0, 0, "R1 clean ones");
    run_case(64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, "R8 layout");
    run_case(64'hDEAD_BEEF_0000_FFFF, 1, 0, 0, 0, "R4 check bit 0");
    run_case(64'h5555_AAAA_5555_AAAA, 1, 13, 0, 0, "R4 check bit 13");
    run_case(64'h1, 1, 14, 0, 0, "R4 data lsb");
    run_case(64'h8000_0000_0000_0000, 1, 77, 0, 0, "R4 data msb");
    run_case(64'hCAFE_F00D_1234_5678, 1, 78, 0, 0, "R4 parity bit");
    run_case(64'h0F0F_0F0F_F0F0_F0F0, 2, 14, 77, 0, "R5 data ends");
    run_case(64'h1111_2222_3333_4444, 2, 0, 78, 0, "R5 check+parity");
    run_case(64'h9999_8888_7777_6666, 2, 77, 78, 0, "R5 data+parity");
    run_case(64'hABCD_EF01_2345_6789, 2, 5, 40, 0, "R5 check+data");
    run_case(64'h0, 3, 14, 15, 16, "R7 triple adjacent");
    run_case(64'hFFFF_0000_FFFF_0000, 3, 0, 50, 78, "R6 triple with parity");

    for (int t = 0; t < 800; t++) begin
      logic [DATA_W-1:0] d = {$urandom, $urandom};
      int n = int'($urandom_range(3, 0));
      int p0 = int'($urandom_range(N_POS, 0));
      int p1, p2;
      do p1 = int'($urandom_range(N_POS, 0)); while (p1 == p0);
      do p2 = int'($urandom_range(N_POS, 0)); while (p2 == p0 || p2 == p1);
      case (n)
        0: run_case(d, n, p0, p1, p2, "R6 random clean");
        1: run_case(d, n, p0, p1, p2, "R4 random single");
        2: run_case(d, n, p0, p1, p2, "R5 random double");
        default: run_case(d, n, p0, p1, p2, "R6 random triple");
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule